// File: doc/BRIEF.md
# Shared Multi-Line Receive Silo with Fill-Level Interrupt

This block gathers characters from sixteen serial line receivers into a single 64-entry first-in first-out store that all lines share. Each line has a one-character holding stage. A round-robin arbiter drains the holding stages into the store, one per clock. Each stored entry records the character, the number of the line that delivered it, and three error flags. Framing and parity errors come from the receiver. The per-line overrun flag is set when a holding stage is overwritten before it was drained.

Software takes entries through a 16-bit receive word. A read strobe pops the entry at the head. A DONE status rises while the fill level is at or above a threshold, which is chosen by four select bits. An interrupt request follows DONE when interrupt enable is set. A character that finds the store full is lost, and a sticky overflow status is raised. A master clear returns everything to its reset state.

Top module: `rx_silo_top`

## Requirements
- R1: The receive word is {bit15 present, bit14 overrun, bit13 framing error, bit12 parity error, bits11:8 line number, bits7:0 character}. A strobe sampled at clock edge k makes the character visible at the head after edge k+1, when no other line is waiting.
- R2: Entries come out in the order they were stored, across all lines, and the store holds up to 64 entries.
- R3: A character that reaches the store while it holds 64 entries, with no pop in the same cycle, is discarded. It sets fifo_ovf, which stays at 1 until master clear.
- R4: When a pop and a push fall in the same cycle with the store full, both take effect. The entry is kept and fifo_ovf stays at 0.
- R5: done is 1 while the fill level is at or above the threshold. The threshold is the sum of 1 (thr_sel bit0), 5 (bit1), 9 (bit2) and 17 (bit3), and it is 1 when thr_sel is 0.
- R6: irq is 1 exactly when done and rx_ie are both 1.
- R7: When the store is empty the receive word is all zero, with present clear. A read strobe in that state changes nothing.
- R8: While rx_en is 0, line strobes are ignored.
- R9: mclr empties the store and all holding stages, clears fifo_ovf and returns the arbiter to line 0.
- R10: Lines waiting at the same time are stored in round-robin order. The search starts at the line after the one granted last, and at line 0 after reset or clear.
- R11: A strobe on a line whose holding stage is still waiting replaces the held character, and the replacing entry carries overrun = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 16 | Per-line character strobe |
| line_chr | input | 128 | Per-line character, line n at bits 8n+7:8n |
| line_ferr | input | 16 | Per-line framing error, valid with strobe |
| line_perr | input | 16 | Per-line parity error, valid with strobe |
| rd_stb | input | 1 | Pops the head entry |
| rx_en | input | 1 | Receiver enable |
| rx_ie | input | 1 | Receive interrupt enable |
| mclr | input | 1 | Synchronous master clear |
| thr_sel | input | 4 | Threshold selects for 1, 5, 9, 17 |
| rd_word | output | 16 | Receive word at the head |
| done | output | 1 | Fill level at or above threshold |
| fifo_ovf | output | 1 | Sticky overflow status |
| irq | output | 1 | Receive interrupt request |

## Verification
A push from the arbiter and a software pop can fall in the same cycle. This matters most when the store is full, because a pop that is ignored or counted late would make the push be lost. The bench fills the store to 64 entries. It then strobes one more character and raises the read strobe in the cycle the arbiter presents that character. It judges the result by three things: fifo_ovf stays 0, the popped word was the oldest entry, and the new character comes out last after 63 older ones. The bench also makes a holding-stage overwrite coincide with the arbiter granting another line, and then checks the overrun flag of the replacing entry.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

    localparam int unsigned THR_W = 6;

    typedef struct packed {
        logic orun;
        logic ferr;
        logic perr;
    } rx_flags_t;

    // Sum of the selected fill levels; no selection means level 1.
    function automatic logic [THR_W-1:0] thr_level(input logic [3:0] sel);
        logic [THR_W-1:0] acc;
        acc = '0;
        if (sel[0]) acc = acc + THR_W'(1);
        if (sel[1]) acc = acc + THR_W'(5);
        if (sel[2]) acc = acc + THR_W'(9);
        if (sel[3]) acc = acc + THR_W'(17);
        if (acc == '0) acc = THR_W'(1);
        return acc;
    endfunction

endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
    import rx_silo_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              stb,
    input  logic [CHAR_W-1:0] chr,
    input  logic              ferr,
    input  logic              perr,
    input  logic              grant,
    output logic              valid,
    output logic [CHAR_W-1:0] chr_o,
    output rx_flags_t         flags_o
);

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] chr;
        rx_flags_t         fl;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (grant) begin
            st_d.valid = 1'b0;
        end
        if (stb && en) begin
            st_d.valid   = 1'b1;
            st_d.chr     = chr;
            st_d.fl.ferr = ferr;
            st_d.fl.perr = perr;
            // previous character still waiting and not leaving now: lost
            st_d.fl.orun = st_q.valid && !grant;
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid   = st_q.valid;
    assign chr_o   = st_q.chr;
    assign flags_o = st_q.fl;

endmodule

// File: rtl/rx_rr_arb.sv
module rx_rr_arb #(
    parameter int unsigned N = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] gidx,
    output logic             any
);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        grant = '0;
        gidx  = '0;
        any   = 1'b0;
        for (int unsigned i = 0; i < N; i++) begin
            int unsigned cand;
            cand = (int'(st_q.ptr) + i) % N;
            if (!any && req[cand]) begin
                any         = 1'b1;
                gidx        = IDX_W'(cand);
                grant[cand] = 1'b1;
            end
        end

        st_d = st_q;
        if (any) begin
            st_d.ptr = (int'(gidx) == N - 1) ? '0 : gidx + IDX_W'(1);
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned ENT_W = 15,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [ENT_W-1:0] din,
    input  logic             pop,
    output logic [ENT_W-1:0] dout,
    output logic [CNT_W-1:0] fill,
    output logic             dropped
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic             pop_eff;
    logic             push_acc;

    always_comb begin
        pop_eff  = pop && (st_q.cnt != '0) && !clr;
        push_acc = push && !clr && ((st_q.cnt != CNT_W'(DEPTH)) || pop_eff);
        dropped  = push && !clr && !push_acc;

        st_d = st_q;
        if (push_acc) begin
            st_d.wr = (int'(st_q.wr) == DEPTH - 1) ? '0 : st_q.wr + PTR_W'(1);
        end
        if (pop_eff) begin
            st_d.rd = (int'(st_q.rd) == DEPTH - 1) ? '0 : st_q.rd + PTR_W'(1);
        end
        case ({push_acc, pop_eff})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_acc) mem_q[st_q.wr] <= din;
    end

    assign dout = mem_q[st_q.rd];
    assign fill = st_q.cnt;

endmodule

// File: rtl/rx_silo_top.sv
module rx_silo_top
    import rx_silo_pkg::*;
#(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned CHAR_W    = 8,
    localparam int unsigned LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int unsigned ENT_W  = 3 + LINE_W + CHAR_W,
    localparam int unsigned WORD_W = ENT_W + 1,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        line_stb,
    input  logic [NUM_LINES*CHAR_W-1:0] line_chr,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic                        rd_stb,
    input  logic                        rx_en,
    input  logic                        rx_ie,
    input  logic                        mclr,
    input  logic [3:0]                  thr_sel,
    output logic [WORD_W-1:0]           rd_word,
    output logic                        done,
    output logic                        fifo_ovf,
    output logic                        irq
);

    typedef struct packed {
        logic ovf;
    } ctl_t;

    logic [NUM_LINES-1:0] hold_v;
    logic [CHAR_W-1:0]    hold_chr [NUM_LINES];
    rx_flags_t            hold_fl  [NUM_LINES];
    logic [NUM_LINES-1:0] arb_grant;
    logic [LINE_W-1:0]    arb_idx;
    logic                 push_req;
    logic [ENT_W-1:0]     push_ent;
    logic [ENT_W-1:0]     head_ent;
    logic [CNT_W-1:0]     fill;
    logic                 drop_pulse;
    logic [CNT_W-1:0]     thr_cnt;
    ctl_t                 ctl_d, ctl_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        rx_line_hold #(.CHAR_W(CHAR_W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (mclr),
            .en      (rx_en),
            .stb     (line_stb[g]),
            .chr     (line_chr[g*CHAR_W +: CHAR_W]),
            .ferr    (line_ferr[g]),
            .perr    (line_perr[g]),
            .grant   (arb_grant[g]),
            .valid   (hold_v[g]),
            .chr_o   (hold_chr[g]),
            .flags_o (hold_fl[g])
        );
    end

    rx_rr_arb #(.N(NUM_LINES)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (mclr),
        .req   (hold_v),
        .grant (arb_grant),
        .gidx  (arb_idx),
        .any   (push_req)
    );

    always_comb begin
        push_ent = {hold_fl[arb_idx], arb_idx, hold_chr[arb_idx]};
    end

    rx_silo_fifo #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mclr),
        .push    (push_req),
        .din     (push_ent),
        .pop     (rd_stb),
        .dout    (head_ent),
        .fill    (fill),
        .dropped (drop_pulse)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (drop_pulse) ctl_d.ovf = 1'b1;
        if (mclr)       ctl_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign thr_cnt  = CNT_W'(thr_level(thr_sel));
    assign done     = (fill >= thr_cnt);
    assign irq      = done && rx_ie;
    assign fifo_ovf = ctl_q.ovf;
    assign rd_word  = (fill != '0) ? {1'b1, head_ent} : '0;

endmodule

// File: rtl/rx_silo_chk.sv
module rx_silo_chk #(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned CNT_W     = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mclr,
    input logic                 rd_stb,
    input logic                 push_req,
    input logic                 fifo_ovf,
    input logic                 done,
    input logic [CNT_W-1:0]     fill,
    input logic [NUM_LINES-1:0] arb_grant
);

    // R2: fill level never exceeds capacity
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R2: fill level moves by at most one per cycle outside clear
    p_fill_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mclr |=> ((fill == $past(fill)) || (fill == $past(fill) + CNT_W'(1))
                   || (fill == $past(fill) - CNT_W'(1))));

    // R3: overflow status is sticky until clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !mclr) |=> fifo_ovf);

    // R5: done never stands with an empty store (threshold is at least 1)
    p_done_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fill != '0));

    // R7: read of an empty store leaves it empty
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && fill == '0 && !push_req) |=> (fill == '0));

    // R9: master clear empties the store and clears overflow
    p_mclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (fill == '0 && !fifo_ovf));

    // R10: at most one line granted per cycle
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_grant));

endmodule

bind rx_silo_top rx_silo_chk #(
    .NUM_LINES (NUM_LINES),
    .DEPTH     (DEPTH),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .rd_stb    (rd_stb),
    .push_req  (push_req),
    .fifo_ovf  (fifo_ovf),
    .done      (done),
    .fill      (fill),
    .arb_grant (arb_grant)
);

// File: tb/tb_rx_silo_top.sv
module tb_rx_silo_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  line_stb = '0;
    logic [127:0] line_chr = '0;
    logic [15:0]  line_ferr = '0;
    logic [15:0]  line_perr = '0;
    logic         rd_stb = 1'b0;
    logic         rx_en = 1'b1;
    logic         rx_ie = 1'b0;
    logic         mclr = 1'b0;
    logic [3:0]   thr_sel = 4'b0001;
    logic [15:0]  rd_word;
    logic         done;
    logic         fifo_ovf;
    logic         irq;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rx_silo_top dut (
        .clk (clk), .rst_n (rst_n),
        .line_stb (line_stb), .line_chr (line_chr),
        .line_ferr (line_ferr), .line_perr (line_perr),
        .rd_stb (rd_stb), .rx_en (rx_en), .rx_ie (rx_ie), .mclr (mclr),
        .thr_sel (thr_sel), .rd_word (rd_word), .done (done),
        .fifo_ovf (fifo_ovf), .irq (irq)
    );

    // vector: {line[3:0], char[7:0], ferr, perr}
    localparam logic [13:0] VEC [8] = '{
        {4'd0,  8'h41, 1'b0, 1'b0},
        {4'd15, 8'hFF, 1'b0, 1'b1},
        {4'd7,  8'h00, 1'b1, 1'b0},
        {4'd3,  8'h5A, 1'b1, 1'b1},
        {4'd15, 8'h80, 1'b0, 1'b0},
        {4'd8,  8'h01, 1'b0, 1'b1},
        {4'd1,  8'hC3, 1'b1, 1'b0},
        {4'd12, 8'h7E, 1'b0, 1'b0}
    };

    function automatic logic [15:0] word_of(input logic [3:0] ln, input logic [7:0] ch,
                                            input logic o, input logic fe, input logic pe);
        return {1'b1, o, fe, pe, ln, ch};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_line(input int ln, input logic [7:0] ch, input logic fe, input logic pe);
        line_stb[ln] = 1'b1;
        line_chr[ln*8 +: 8] = ch;
        line_ferr[ln] = fe;
        line_perr[ln] = pe;
    endtask

    task automatic push_one(input int ln, input logic [7:0] ch, input logic fe, input logic pe);
        set_line(ln, ch, fe, pe);
        @(negedge clk);
        line_stb = '0;
        @(negedge clk);
    endtask

    task automatic read_one(output logic [15:0] w);
        w = rd_word;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_clear();
        mclr = 1'b1;
        @(negedge clk);
        mclr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] w;
        logic [15:0] x_word;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R7 reset word", rd_word, 16'h0000);
        check("R3 reset ovf", {15'b0, fifo_ovf}, 16'h0);
        check("R5 reset done", {15'b0, done}, 16'h0);

        // R1 / R2: table walk, push all then read back in order
        for (int i = 0; i < 8; i++) begin
            push_one(int'(VEC[i][13:10]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
            if (i == 0) check("R1 latency head", rd_word, word_of(VEC[0][13:10], VEC[0][9:2], 1'b0, VEC[0][1], VEC[0][0]));
        end
        for (int i = 0; i < 8; i++) begin
            read_one(w);
            check("R1 R2 table entry", w, word_of(VEC[i][13:10], VEC[i][9:2], 1'b0, VEC[i][1], VEC[i][0]));
        end

        // R7: empty read returns zero and does not disturb pointers
        check("R7 empty word", rd_word, 16'h0000);
        read_one(w);
        check("R7 empty read value", w, 16'h0000);
        push_one(5, 8'h99, 1'b0, 1'b0);
        check("R7 after empty read", rd_word, word_of(4'd5, 8'h99, 1'b0, 1'b0, 1'b0));
        read_one(w);
        check("R7 empty again", rd_word, 16'h0000);

        // R10: simultaneous strobes from pointer 0 after clear
        do_clear();
        set_line(5, 8'h55, 1'b0, 1'b0);
        set_line(2, 8'h22, 1'b0, 1'b0);
        set_line(9, 8'h99, 1'b0, 1'b0);
        @(negedge clk);
        line_stb = '0;
        repeat (4) @(negedge clk);
        read_one(w); check("R10 first", w, word_of(4'd2, 8'h22, 1'b0, 1'b0, 1'b0));
        read_one(w); check("R10 second", w, word_of(4'd5, 8'h55, 1'b0, 1'b0, 1'b0));
        read_one(w); check("R10 third", w, word_of(4'd9, 8'h99, 1'b0, 1'b0, 1'b0));
        // pointer now at 10: line 12 precedes line 1
        set_line(1, 8'h11, 1'b0, 1'b0);
        set_line(12, 8'hCC, 1'b0, 1'b0);
        @(negedge clk);
        line_stb = '0;
        repeat (3) @(negedge clk);
        read_one(w); check("R10 rotate first", w, word_of(4'd12, 8'hCC, 1'b0, 1'b0, 1'b0));
        read_one(w); check("R10 rotate second", w, word_of(4'd1, 8'h11, 1'b0, 1'b0, 1'b0));

        // R11: overwrite of a waiting holding stage
        do_clear();
        for (int l = 0; l < 4; l++) set_line(l, 8'hA0 + 8'(l), 1'b0, 1'b0);
        @(negedge clk);
        line_stb = '0;
        set_line(3, 8'hB3, 1'b0, 1'b0);
        @(negedge clk);
        line_stb = '0;
        repeat (4) @(negedge clk);
        read_one(w); check("R11 line0 clean", w, word_of(4'd0, 8'hA0, 1'b0, 1'b0, 1'b0));
        read_one(w); check("R11 line1 clean", w, word_of(4'd1, 8'hA1, 1'b0, 1'b0, 1'b0));
        read_one(w); check("R11 line2 clean", w, word_of(4'd2, 8'hA2, 1'b0, 1'b0, 1'b0));
        read_one(w); check("R11 line3 overrun", w, word_of(4'd3, 8'hB3, 1'b1, 1'b0, 1'b0));
        check("R11 nothing extra", rd_word, 16'h0000);

        // R8: strobes ignored while disabled
        rx_en = 1'b0;
        push_one(7, 8'h77, 1'b0, 1'b0);
        @(negedge clk);
        check("R8 disabled ignored", rd_word, 16'h0000);
        rx_en = 1'b1;

        // R5 / R6: threshold and interrupt
        do_clear();
        thr_sel = 4'b0010;
        rx_ie = 1'b1;
        for (int i = 0; i < 4; i++) push_one(4, 8'(i), 1'b0, 1'b0);
        check("R5 below 5", {15'b0, done}, 16'h0);
        check("R6 irq low", {15'b0, irq}, 16'h0);
        push_one(4, 8'h04, 1'b0, 1'b0);
        check("R5 at 5", {15'b0, done}, 16'h1);
        check("R6 irq high", {15'b0, irq}, 16'h1);
        rx_ie = 1'b0;
        #1;
        check("R6 irq masked", {15'b0, irq}, 16'h0);
        thr_sel = 4'b1111;
        #1;
        check("R5 sum 32", {15'b0, done}, 16'h0);
        thr_sel = 4'b0000;
        #1;
        check("R5 none is 1", {15'b0, done}, 16'h1);
        thr_sel = 4'b0110;
        #1;
        check("R5 sum 14", {15'b0, done}, 16'h0);
        thr_sel = 4'b0001;

        // R2 / R4 / R3: full store, concurrent push and pop, then overflow
        do_clear();
        for (int i = 0; i < 64; i++) push_one(0, 8'(i), 1'b0, 1'b0);
        check("R2 full ovf clear", {15'b0, fifo_ovf}, 16'h0);
        x_word = word_of(4'd6, 8'hEE, 1'b0, 1'b1, 1'b0);
        set_line(6, 8'hEE, 1'b1, 1'b0);
        @(negedge clk);
        line_stb = '0;
        w = rd_word;
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R4 popped oldest", w, word_of(4'd0, 8'h00, 1'b0, 1'b0, 1'b0));
        check("R4 no overflow", {15'b0, fifo_ovf}, 16'h0);
        push_one(9, 8'h33, 1'b0, 1'b0);
        check("R3 overflow set", {15'b0, fifo_ovf}, 16'h1);
        bad = 0;
        for (int i = 1; i < 64; i++) begin
            read_one(w);
            if (w !== word_of(4'd0, 8'(i), 1'b0, 1'b0, 1'b0)) bad++;
        end
        check("R2 63 older entries in order", 16'(bad), 16'h0);
        read_one(w);
        check("R4 kept entry last", w, x_word);
        check("R3 dropped not stored", rd_word, 16'h0000);
        check("R3 ovf sticky", {15'b0, fifo_ovf}, 16'h1);

        // R9: master clear
        push_one(2, 8'h12, 1'b0, 1'b0);
        set_line(3, 8'h13, 1'b0, 1'b0);
        @(negedge clk);
        line_stb = '0;
        do_clear();
        @(negedge clk);
        check("R9 store empty", rd_word, 16'h0000);
        check("R9 ovf cleared", {15'b0, fifo_ovf}, 16'h0);
        check("R9 done cleared", {15'b0, done}, 16'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule